// File: doc/BRIEF.md
# Bitmap-Based Best Matching Unit Finder

This block serves the winner search of a self-organizing-map quantizer. In one cycle it accepts one distance value from every processing element. It returns the smallest of those distances and the number of the element that produced it. It uses no comparator tree. Each distance sets a one-bit flag in an array that has one entry for every possible distance value. The smallest distance is then the lowest address that holds a set flag.

That lowest set flag is found in two levels. First, the flag array is cut into fixed-width groups. Each group reports whether any of its flags is set and the offset of its first set flag. Second, a final stage picks the lowest group that is not empty, which gives the minimum. In the same stage every input is compared with the minimum, and a priority encoder returns the lowest-numbered element that matches.

The search takes three fixed stages: mark, group search, and select with index encode. A new vector may enter on every cycle, and results leave in the order their vectors entered.

Top module: `bmu_seek`

## Requirements
- R1: While reset (`rstN` low) is applied and after it is released, `doneOut` is 0 and `minDist` and `winIdx` are 0 until the first result arrives.
- R2: Each accepted vector marks one flag per distance. The reported `minDist` equals the smallest of the NUM_PE unsigned DIST_W-bit values, which are packed with element i at bits [i*DIST_W +: DIST_W] of `distVec`.
- R3: The flags are rebuilt from scratch for every accepted vector. A result depends only on its own vector, even when the previous vector had a smaller minimum.
- R4: The minimum is found wherever it lies in the flag array, including address 0, address 2^DIST_W-1, and both sides of a boundary between groups of GROUP_W flags.
- R5: `winIdx` is the index of an element whose distance equals `minDist`. When several elements tie, the lowest index is reported.
- R6: `doneOut` is high for exactly one cycle, in the third cycle after the rising clock edge that samples `startIn` high. It is never high without such a start.
- R7: `startIn` may be high on consecutive cycles. Each accepted vector then yields its own result, one per cycle, in the order of acceptance.
- R8: `minDist` and `winIdx` keep their values in every cycle in which `doneOut` is low. `distVec` has no effect while `startIn` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Accept `distVec` on this clock edge |
| distVec | input | NUM_PE*DIST_W | All distances, element i at bits [i*DIST_W +: DIST_W] |
| minDist | output | DIST_W | Smallest distance of the accepted vector |
| winIdx | output | $clog2(NUM_PE) | Lowest element index holding `minDist` |
| doneOut | output | 1 | One-cycle strobe marking a valid result |

## Verification
Two functions meet in one cycle when starts arrive back to back. In that cycle the mark stage writes a fresh flag array while the select stage is still resolving and encoding an older vector. The bench provokes this with runs of consecutive starts, each with a different minimum position. It also places a small minimum right before a large one, so that a flag left over from the earlier vector would show up in the later result. Every clock, a reference scans each vector linearly for its first minimum and checks that `doneOut` and the result appear exactly in the cycle that vector is due. On cycles with no result due, it checks that the outputs hold their previous values.

// File: rtl/bmu_seek_pkg.sv
package bmu_seek_pkg;
  // One enable per pipeline stage, driven by control into the datapath
  typedef struct packed {
    logic markEn;
    logic searchEn;
    logic selectEn;
  } stage_strobes_t;
endpackage

// File: rtl/bmu_seek_ctrl.sv
module bmu_seek_ctrl
  import bmu_seek_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           startIn,
  output stage_strobes_t strobes,
  output logic           doneOut
);
  logic markedV;
  logic searchedV;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      markedV   <= 1'b0;
      searchedV <= 1'b0;
      doneOut   <= 1'b0;
    end else begin
      markedV   <= startIn;
      searchedV <= markedV;
      doneOut   <= searchedV;
    end
  end

  always_comb begin
    strobes.markEn   = startIn;
    strobes.searchEn = markedV;
    strobes.selectEn = searchedV;
  end

  // R6: a result strobe follows every start after three edges
  assert_done_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    startIn |-> ##3 doneOut);
  // R6: no strobe without a start three cycles earlier
  assert_no_spurious_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> $past(startIn, 3));
endmodule

// File: rtl/bmu_seek_datapath.sv
module bmu_seek_datapath
  import bmu_seek_pkg::*;
#(
  parameter int NUM_PE  = 256,
  parameter int DIST_W  = 8,
  parameter int GROUP_W = 16,
  localparam int IDX_W  = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  stage_strobes_t           strobes,
  input  logic [NUM_PE*DIST_W-1:0] distVec,
  output logic [DIST_W-1:0]        minDist,
  output logic [IDX_W-1:0]         winIdx
);
  localparam int K          = 1 << DIST_W;
  localparam int NUM_GROUPS = K / GROUP_W;
  localparam int OFF_W      = $clog2(GROUP_W);
  localparam int GRP_W      = DIST_W - OFF_W;

  // ---------------- stage 1: mark ----------------
  logic [K-1:0]             markVec;
  logic [K-1:0]             flagReg;
  logic [NUM_PE*DIST_W-1:0] dist1;

  always_comb begin
    markVec = '0;
    for (int i = 0; i < NUM_PE; i++)
      markVec[distVec[i*DIST_W +: DIST_W]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobes.markEn) begin
      flagReg <= markVec;
      dist1   <= distVec;
    end
  end

  // ---------------- stage 2: group search ----------------
  logic [NUM_GROUPS-1:0]    grpAny;
  logic [OFF_W-1:0]         grpOff [NUM_GROUPS];
  logic [NUM_GROUPS-1:0]    anyReg;
  logic [OFF_W-1:0]         offReg [NUM_GROUPS];
  logic [NUM_PE*DIST_W-1:0] dist2;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    logic [GROUP_W-1:0] slice;
    assign slice     = flagReg[g*GROUP_W +: GROUP_W];
    assign grpAny[g] = |slice;

    always_comb begin
      grpOff[g] = '0;
      for (int b = GROUP_W - 1; b >= 0; b--)
        if (slice[b]) grpOff[g] = OFF_W'(b);
    end

    always_ff @(posedge clk) begin
      if (strobes.searchEn) begin
        anyReg[g] <= grpAny[g];
        offReg[g] <= grpOff[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.searchEn) dist2 <= dist1;
  end

  // ---------------- stage 3: final select and index encode ----------------
  logic [GRP_W-1:0]  selGrp;
  logic [DIST_W-1:0] minComb;
  logic [NUM_PE-1:0] matchVec;
  logic [IDX_W-1:0]  encIdx;

  always_comb begin
    selGrp = '0;
    for (int g = NUM_GROUPS - 1; g >= 0; g--)
      if (anyReg[g]) selGrp = GRP_W'(g);
  end

  assign minComb = {selGrp, offReg[selGrp]};

  for (genvar i = 0; i < NUM_PE; i++) begin : g_match
    assign matchVec[i] = (dist2[i*DIST_W +: DIST_W] == minComb);
  end

  always_comb begin
    encIdx = '0;
    for (int i = NUM_PE - 1; i >= 0; i--)
      if (matchVec[i]) encIdx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      minDist <= '0;
      winIdx  <= '0;
    end else if (strobes.selectEn) begin
      minDist <= minComb;
      winIdx  <= encIdx;
    end
  end

  // R2: element 0's distance is always marked in the flag array
  assert_pe0_marked_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.markEn |=> flagReg[$past(distVec[DIST_W-1:0])]);
  // R4: at least one group holds a set flag whenever a select happens
  assert_group_found_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selectEn |-> (anyReg != '0));
  // R5: the encoded winner really carries the selected minimum
  assert_index_matches_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selectEn |-> (dist2[encIdx*DIST_W +: DIST_W] == minComb));
  // R8: outputs move only on a select edge
  assert_outputs_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.selectEn) |-> ($stable(minDist) && $stable(winIdx)));
endmodule

// File: rtl/bmu_seek.sv
module bmu_seek
  import bmu_seek_pkg::*;
#(
  parameter int NUM_PE  = 256,
  parameter int DIST_W  = 8,
  parameter int GROUP_W = 16,
  localparam int IDX_W  = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startIn,
  input  logic [NUM_PE*DIST_W-1:0] distVec,
  output logic [DIST_W-1:0]        minDist,
  output logic [IDX_W-1:0]         winIdx,
  output logic                     doneOut
);
  stage_strobes_t strobes;

  bmu_seek_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .strobes (strobes),
    .doneOut (doneOut)
  );

  bmu_seek_datapath #(
    .NUM_PE  (NUM_PE),
    .DIST_W  (DIST_W),
    .GROUP_W (GROUP_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .distVec (distVec),
    .minDist (minDist),
    .winIdx  (winIdx)
  );
endmodule

// File: tb/bmu_seek_tb.sv
module bmu_seek_tb;
  localparam int NUM_PE = 256;
  localparam int DIST_W = 8;
  localparam int IDX_W  = $clog2(NUM_PE);

  logic                     clk = 1'b0;
  logic                     rstN = 1'b0;
  logic                     startIn = 1'b0;
  logic [NUM_PE*DIST_W-1:0] distVec = '0;
  logic [DIST_W-1:0]        minDist;
  logic [IDX_W-1:0]         winIdx;
  logic                     doneOut;

  bmu_seek #(.NUM_PE(NUM_PE), .DIST_W(DIST_W), .GROUP_W(16)) u_dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .distVec(distVec),
    .minDist(minDist), .winIdx(winIdx), .doneOut(doneOut)
  );

  always #5 clk = ~clk;

  int    cyc = 0;
  int    nTests = 0;
  int    nFail = 0;
  bit    checking = 1'b0;
  int    lastMin = 0;
  int    lastIdx = 0;
  int    dueQ[$];
  int    mnQ[$];
  int    ixQ[$];
  string tagQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Reference: linear scan for the first minimum
  task automatic issue(string tag);
    int mn = 1 << DIST_W;
    int ix = 0;
    for (int i = 0; i < NUM_PE; i++) begin
      int d = int'(distVec[i*DIST_W +: DIST_W]);
      if (d < mn) begin mn = d; ix = i; end
    end
    dueQ.push_back(cyc + 3);
    mnQ.push_back(mn);
    ixQ.push_back(ix);
    tagQ.push_back(tag);
    startIn = 1'b1;
    @(posedge clk); #1;
    startIn = 1'b0;
  endtask

  task automatic fillRandom();
    for (int i = 0; i < NUM_PE; i++) distVec[i*DIST_W +: DIST_W] = 8'($urandom);
  endtask

  task automatic fillConst(int v);
    for (int i = 0; i < NUM_PE; i++) distVec[i*DIST_W +: DIST_W] = 8'(v);
  endtask

  // Per-cycle comparison against the reference queue
  always @(negedge clk) begin
    if (checking) begin
      if (dueQ.size() > 0 && dueQ[0] == cyc) begin
        check({tagQ[0], " R6 done"}, int'(doneOut), 1);
        check({tagQ[0], " R2 min"}, int'(minDist), mnQ[0]);
        check({tagQ[0], " R5 idx"}, int'(winIdx), ixQ[0]);
        lastMin = mnQ[0];
        lastIdx = ixQ[0];
        void'(dueQ.pop_front()); void'(mnQ.pop_front());
        void'(ixQ.pop_front());  void'(tagQ.pop_front());
      end else begin
        check("R6 no done", int'(doneOut), 0);
        check("R8 min hold", int'(minDist), lastMin);
        check("R8 idx hold", int'(winIdx), lastIdx);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check("R1 done in reset", int'(doneOut), 0);
    check("R1 min in reset", int'(minDist), 0);
    check("R1 idx in reset", int'(winIdx), 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    checking = 1'b1;

    // R2: random vectors, spaced apart
    for (int n = 0; n < 6; n++) begin
      fillRandom();
      issue("R2 random");
      repeat (4) @(posedge clk); #1;
    end

    // R8: distVec churns with no start; outputs must hold
    for (int n = 0; n < 5; n++) begin
      fillConst(0);
      @(posedge clk); #1;
    end

    // R4: minimum at address 0 on the last element
    fillConst(200); distVec[(NUM_PE-1)*DIST_W +: DIST_W] = 8'd0;
    issue("R4 addr0 last");
    // R4/R5: all at the top address, tie on every element
    fillConst(255);
    issue("R4 top all tie");
    // R4: group boundary 15 vs 16
    fillConst(100); distVec[40*DIST_W +: DIST_W] = 8'd16; distVec[90*DIST_W +: DIST_W] = 8'd15;
    issue("R4 boundary 15");
    fillConst(100); distVec[40*DIST_W +: DIST_W] = 8'd16; distVec[90*DIST_W +: DIST_W] = 8'd17;
    issue("R4 boundary 16");
    // R5: ties at two indices, lowest wins
    fillConst(77); distVec[200*DIST_W +: DIST_W] = 8'd10; distVec[7*DIST_W +: DIST_W] = 8'd10;
    issue("R5 tie");
    // R3: small minimum followed by large minimum
    fillConst(240); distVec[3*DIST_W +: DIST_W] = 8'd1;
    issue("R3 small");
    fillConst(240); distVec[250*DIST_W +: DIST_W] = 8'd239;
    issue("R3 large after small");
    // R7: long back-to-back run of random vectors
    for (int n = 0; n < 20; n++) begin
      fillRandom();
      issue("R7 b2b");
    end
    repeat (8) @(posedge clk); #1;
    checking = 1'b0;
    check("R7 queue drained", dueQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule